// File: doc/BRIEF.md
# Host Mailbox Port

This block is the device side of a byte-wide parallel host port. A host processor reaches it through 8 data bits and 4 address bits, with an active-low enable, an active-low strobe and a read/write select (high means read). Behind the port sit two independent 32-bit conduits, one for messages and one for data. Each conduit is four byte registers. The host assembles a word a byte at a time, with the most significant byte first. The last byte of a conduit is the trigger: writing it commits the assembled word, and reading it moves to the next word.

A data-conduit word that the host writes lands in an inbound word FIFO, which device logic drains. Device logic fills an outbound word FIFO that the host reads through the data conduit. A word the host writes to the message conduit is decoded as a command. A message-conduit read returns a pipelined status word. A request line tells the host whether data can be read or written, and the last command selects which of the two it reports. An active-low alert line is raised by enabled device events and is cleared only by an acknowledge message.

Inputs are sampled on the device clock. An access starts on the first clock at which both enable and strobe are sampled low, and it acts once, at that edge.

Top module: `hostmbx_port`

## Requirements
- R1: An access starts on the first clock edge at which `hst_en_n` and `hst_ds_n` are both sampled low, and it takes effect once per access. `hst_rw`=1 makes it a read. `hst_data_oe` is high in the cycles after each edge at which the access was sampled active and low otherwise. The read byte appears on `hst_data_o` in the cycle after the start. `hst_data_o` is 0x00 after any edge at which no access is active.
- R2: The address map is as follows. Addresses 0..3 are message bytes A..D and 4..7 are data bytes A..D. Address 14 is the alert-enable mask (read/write). Address 15 is the read-only port status: bit0 write mode, bit1 outbound word available, bit2 inbound FIFO full, other bits 0. Addresses 8..13 read as 0x00, and writes to them are ignored.
- R3: Writing data byte D pushes {A,B,C,D} into the inbound FIFO, with A as bits 31:24. A word written while the FIFO is full is dropped.
- R4: Data bytes A..D read back a snapshot register, A being bits 31:24. A read of data byte D returns its byte and then loads the snapshot with the next outbound word, or with 0 if none is waiting. The first word read after reset is therefore 0, and each later word is the one fetched at the previous D read.
- R5: Writing message byte D commits a command. The opcode is bits 31:24 and is recognised only when bits 23:0 are zero: 0x01 acknowledge, 0x10 select read mode, 0x11 select write mode.
- R6: Message bytes A..D read a status snapshot, which is captured at each read of message byte D and is 0 after reset. Status layout: bit0 completion toggle, bit1 write mode, bit2 alert active, bit3 inbound full, bit4 outbound word available, other bits 0.
- R7: The completion toggle inverts once for every committed message, whatever its opcode, and holds otherwise.
- R8: The request mode is read after reset. A recognised 0x10 selects read mode and a recognised 0x11 selects write mode. Every other message leaves the mode unchanged.
- R9: In read mode `hst_req` is low while an outbound word is waiting. In write mode it is high while the inbound FIFO has space. It follows the internal state with one cycle of delay.
- R10: `hst_alert_n` goes low at the clock after any `dev_evt` bit that is also set in the mask. It stays low until an acknowledge message is committed. If an enabled event coincides with the acknowledge, the event wins.
- R11: After reset `hst_req`=1, `hst_alert_n`=1, `hst_data_oe`=0, `hst_data_o`=0x00, both FIFOs are empty and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_en_n | input | 1 | Host port enable, active low |
| hst_ds_n | input | 1 | Host data strobe, active low |
| hst_rw | input | 1 | Transfer direction, 1 = read |
| hst_addr | input | 4 | Host register address |
| hst_data_i | input | 8 | Host write data |
| hst_data_o | output | 8 | Host read data |
| hst_data_oe | output | 1 | Read data drive enable for the pad |
| hst_req | output | 1 | Data request line |
| hst_alert_n | output | 1 | Alert line, active low |
| dev_evt | input | EVT_W | Device event pulses |
| dev_rx_valid | output | 1 | Inbound word available |
| dev_rx_ready | input | 1 | Device accepts the inbound word |
| dev_rx_data | output | 32 | Inbound word |
| dev_tx_valid | input | 1 | Outbound word offered |
| dev_tx_ready | output | 1 | Outbound FIFO has space |
| dev_tx_data | input | 32 | Outbound word |

## Verification
The embedded properties watch four things on every cycle. The first is that the pad drive follows the host access window. The second is that the alert stays low until an acknowledge arrives. The third is that the request mode and completion toggle change only on qualifying messages. The fourth is that the snapshot registers move only on a D read, and no FIFO count passes its depth.

Some behaviours need a scripted sequence and a cycle model in the bench. These are the one-word lag of both read pipelines and the byte order of committed words. They also include dropping writes into a full FIFO, the request level in each mode, and the event-beats-acknowledge priority.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int OPC_W      = 8;

  localparam logic [3:0] ADDR_MASK  = 4'd14;
  localparam logic [3:0] ADDR_PSTAT = 4'd15;

  localparam logic [OPC_W-1:0] OPC_ACK   = 8'h01;
  localparam logic [OPC_W-1:0] OPC_GO_RD = 8'h10;
  localparam logic [OPC_W-1:0] OPC_GO_WR = 8'h11;

  typedef enum logic {REQ_RD = 1'b0, REQ_WR = 1'b1} req_mode_e;

  typedef struct packed {
    logic [26:0] rsvd;
    logic        out_avail;
    logic        in_full;
    logic        alert;
    logic        wr_mode;
    logic        toggle;
  } mbx_status_t;
endpackage

// File: rtl/hostmbx_fifo.sv
module hostmbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_full_blocks_push_R3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/hostmbx_stage.sv
module hostmbx_stage import hostmbx_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [WORD_W-1:0] load_word,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word,
  output logic              fetch,
  output logic [BYTE_W-1:0] rbyte
);
  logic [BYTE_W-1:0] hold_a, hold_b, hold_c;
  logic [WORD_W-1:0] snap;

  assign commit      = wr_en && (sel == 2'd3);
  assign fetch       = rd_en && (sel == 2'd3);
  assign commit_word = {hold_a, hold_b, hold_c, wbyte};

  always_comb begin
    case (sel)
      2'd0:    rbyte = snap[31:24];
      2'd1:    rbyte = snap[23:16];
      2'd2:    rbyte = snap[15:8];
      default: rbyte = snap[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
      hold_c <= '0;
      snap   <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          2'd0:    hold_a <= wbyte;
          2'd1:    hold_b <= wbyte;
          2'd2:    hold_c <= wbyte;
          default: ;
        endcase
      end
      if (fetch) snap <= load_word;
    end
  end

  assert_snap_moves_on_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(snap));
endmodule

// File: rtl/hostmbx_cmd.sv
module hostmbx_cmd import hostmbx_pkg::*; #(
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  input  logic [EVT_W-1:0]  evt,
  input  logic [EVT_W-1:0]  mask,
  input  logic              out_empty,
  input  logic              in_full,
  output mbx_status_t       status,
  output logic              req,
  output logic              alert_n
);
  logic [OPC_W-1:0] opc;
  logic             args_zero, is_ack, go_rd, go_wr, evt_hit;
  req_mode_e        mode;
  logic             toggle;

  assign opc       = word[WORD_W-1 -: OPC_W];
  assign args_zero = (word[WORD_W-OPC_W-1:0] == '0);
  assign is_ack    = commit && args_zero && (opc == OPC_ACK);
  assign go_rd     = commit && args_zero && (opc == OPC_GO_RD);
  assign go_wr     = commit && args_zero && (opc == OPC_GO_WR);
  assign evt_hit   = |(evt & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= REQ_RD;
      toggle  <= 1'b0;
      alert_n <= 1'b1;
      req     <= 1'b1;
    end else begin
      req <= (mode == REQ_WR) ? !in_full : out_empty;
      if (commit) toggle <= ~toggle;
      if (go_rd)      mode <= REQ_RD;
      else if (go_wr) mode <= REQ_WR;
      if (evt_hit)     alert_n <= 1'b0;
      else if (is_ack) alert_n <= 1'b1;
    end
  end

  always_comb begin
    status           = '0;
    status.toggle    = toggle;
    status.wr_mode   = (mode == REQ_WR);
    status.alert     = !alert_n;
    status.in_full   = in_full;
    status.out_avail = !out_empty;
  end

  assert_alert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (!alert_n && !is_ack) |=> !alert_n);
  assert_mode_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !(go_rd || go_wr) |=> $stable(mode));
  assert_toggle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(toggle));
endmodule

// File: rtl/hostmbx_port.sv
module hostmbx_port import hostmbx_pkg::*; #(
  parameter int FIFO_DEPTH = 4,
  parameter int EVT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_en_n,
  input  logic              hst_ds_n,
  input  logic              hst_rw,
  input  logic [3:0]        hst_addr,
  input  logic [BYTE_W-1:0] hst_data_i,
  output logic [BYTE_W-1:0] hst_data_o,
  output logic              hst_data_oe,
  output logic              hst_req,
  output logic              hst_alert_n,
  input  logic [EVT_W-1:0]  dev_evt,
  output logic              dev_rx_valid,
  input  logic              dev_rx_ready,
  output logic [WORD_W-1:0] dev_rx_data,
  input  logic              dev_tx_valid,
  output logic              dev_tx_ready,
  input  logic [WORD_W-1:0] dev_tx_data
);
  localparam int N_COND = 2;  // 0: message conduit, 1: data conduit
  localparam int C_MSG  = 0;
  localparam int C_DAT  = 1;

  logic active, acc_q, st, st_rd, st_wr;
  assign active = !hst_en_n && !hst_ds_n;
  assign st     = active && !acc_q;
  assign st_rd  = st && hst_rw;
  assign st_wr  = st && !hst_rw;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= 1'b0;
    else     acc_q <= active;
  end

  logic [N_COND-1:0] c_commit, c_fetch;
  logic [WORD_W-1:0] c_cword [N_COND];
  logic [WORD_W-1:0] c_load  [N_COND];
  logic [BYTE_W-1:0] c_rbyte [N_COND];

  mbx_status_t       status;
  logic [EVT_W-1:0]  mask;
  logic              in_full, in_empty, out_full, out_empty;
  logic [WORD_W-1:0] out_head;

  assign c_load[C_MSG] = status;
  assign c_load[C_DAT] = out_empty ? '0 : out_head;

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    logic hit;
    assign hit = (hst_addr[3:2] == 2'(g));
    hostmbx_stage u_stage (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (st_wr && hit),
      .rd_en       (st_rd && hit),
      .sel         (hst_addr[1:0]),
      .wbyte       (hst_data_i),
      .load_word   (c_load[g]),
      .commit      (c_commit[g]),
      .commit_word (c_cword[g]),
      .fetch       (c_fetch[g]),
      .rbyte       (c_rbyte[g])
    );
  end

  hostmbx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (c_commit[C_DAT]),
    .din   (c_cword[C_DAT]),
    .pop   (dev_rx_valid && dev_rx_ready),
    .dout  (dev_rx_data),
    .full  (in_full),
    .empty (in_empty)
  );
  assign dev_rx_valid = !in_empty;

  hostmbx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (dev_tx_valid),
    .din   (dev_tx_data),
    .pop   (c_fetch[C_DAT]),
    .dout  (out_head),
    .full  (out_full),
    .empty (out_empty)
  );
  assign dev_tx_ready = !out_full;

  hostmbx_cmd #(.EVT_W(EVT_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .commit    (c_commit[C_MSG]),
    .word      (c_cword[C_MSG]),
    .evt       (dev_evt),
    .mask      (mask),
    .out_empty (out_empty),
    .in_full   (in_full),
    .status    (status),
    .req       (hst_req),
    .alert_n   (hst_alert_n)
  );

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (st_wr && hst_addr == ADDR_MASK) mask <= hst_data_i[EVT_W-1:0];
  end

  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    if (hst_addr[3:2] == 2'(C_MSG))      rd_mux = c_rbyte[C_MSG];
    else if (hst_addr[3:2] == 2'(C_DAT)) rd_mux = c_rbyte[C_DAT];
    else if (hst_addr == ADDR_MASK)      rd_mux = BYTE_W'(mask);
    else if (hst_addr == ADDR_PSTAT)     rd_mux = {5'b0, in_full, !out_empty, status.wr_mode};
    else                                 rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_data_o  <= '0;
      hst_data_oe <= 1'b0;
    end else begin
      hst_data_oe <= active;
      if (st_rd)        hst_data_o <= rd_mux;
      else if (!active) hst_data_o <= '0;
    end
  end

  assert_released_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!hst_data_oe && hst_data_o == '0));
  assert_drive_needs_access_R1: assert property (@(posedge clk) disable iff (rst)
    hst_data_oe |-> $past(active));
endmodule

// File: tb/test_hostmbx_port.sv
module test_hostmbx_port;
  localparam int DEPTH = 4;
  localparam int EVT_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_en_n = 1'b1, hst_ds_n = 1'b1, hst_rw = 1'b1;
  logic [3:0]  hst_addr = '0;
  logic [7:0]  hst_data_i = '0;
  logic [7:0]  hst_data_o;
  logic        hst_data_oe, hst_req, hst_alert_n;
  logic [EVT_W-1:0] dev_evt = '0;
  logic        dev_rx_valid, dev_rx_ready = 1'b0;
  logic [31:0] dev_rx_data;
  logic        dev_tx_valid = 1'b0, dev_tx_ready;
  logic [31:0] dev_tx_data = '0;

  always #4 clk = ~clk;

  hostmbx_port #(.FIFO_DEPTH(DEPTH), .EVT_W(EVT_W)) i_hostmbx_port (
    .clk(clk), .rst(rst), .hst_en_n(hst_en_n), .hst_ds_n(hst_ds_n), .hst_rw(hst_rw),
    .hst_addr(hst_addr), .hst_data_i(hst_data_i), .hst_data_o(hst_data_o),
    .hst_data_oe(hst_data_oe), .hst_req(hst_req), .hst_alert_n(hst_alert_n),
    .dev_evt(dev_evt), .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data), .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_tx_data(dev_tx_data)
  );

  int n_cmp = 0, n_bad = 0, n_rx = 0;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_in[$], m_out[$];
  logic [7:0]  m_hold [2][3];
  logic [31:0] m_snap [2];
  logic        m_acc, m_mode, m_toggle, m_alert_n, m_req, m_oe;
  logic [7:0]  m_mask, m_dout;

  function automatic logic [7:0] byte_of(logic [31:0] w, logic [1:0] s);
    return w[8*(3-s) +: 8];
  endfunction

  always @(posedge clk) begin : model
    logic act, st, in_full_o, out_empty_o, out_full_o, alert_o, mode_o;
    logic [7:0] mask_o, rb;
    logic [31:0] stat_o, w;
    int c;
    logic [1:0] s;
    if (rst) begin
      m_in.delete(); m_out.delete();
      for (int i = 0; i < 2; i++) begin
        m_snap[i] = '0;
        for (int j = 0; j < 3; j++) m_hold[i][j] = '0;
      end
      m_acc = 0; m_mode = 0; m_toggle = 0; m_alert_n = 1; m_req = 1; m_oe = 0;
      m_mask = 0; m_dout = 0;
    end else begin
      act = !hst_en_n && !hst_ds_n;
      st = act && !m_acc;
      in_full_o = (m_in.size() == DEPTH);
      out_empty_o = (m_out.size() == 0);
      out_full_o = (m_out.size() == DEPTH);
      alert_o = !m_alert_n;
      mode_o = m_mode;
      mask_o = m_mask;
      stat_o = {27'b0, !out_empty_o, in_full_o, alert_o, mode_o, m_toggle};
      c = hst_addr[2];
      s = hst_addr[1:0];
      if (hst_addr < 8) rb = byte_of(m_snap[c], s);
      else if (hst_addr == 14) rb = mask_o;
      else if (hst_addr == 15) rb = {5'b0, in_full_o, !out_empty_o, mode_o};
      else rb = 0;
      m_oe = act;
      if (st && hst_rw) m_dout = rb;
      else if (!act) m_dout = 0;
      m_req = mode_o ? !in_full_o : out_empty_o;
      if (!(m_in.size() == 0) && dev_rx_ready) void'(m_in.pop_front());
      if (st && hst_rw && hst_addr < 8 && s == 3) begin
        if (c == 0) m_snap[0] = stat_o;
        else begin
          m_snap[1] = out_empty_o ? 32'h0 : m_out[0];
          if (!out_empty_o) void'(m_out.pop_front());
        end
      end
      if (dev_tx_valid && !out_full_o) m_out.push_back(dev_tx_data);
      if (st && !hst_rw) begin
        if (hst_addr < 8) begin
          if (s != 3) m_hold[c][s] = hst_data_i;
          else begin
            w = {m_hold[c][0], m_hold[c][1], m_hold[c][2], hst_data_i};
            if (c == 1) begin
              if (!in_full_o) m_in.push_back(w);
            end else begin
              m_toggle = !m_toggle;
              if (w[23:0] == 0 && w[31:24] == 8'h10) m_mode = 0;
              if (w[23:0] == 0 && w[31:24] == 8'h11) m_mode = 1;
              if (w[23:0] == 0 && w[31:24] == 8'h01 && !(|(dev_evt & mask_o))) m_alert_n = 1;
            end
          end
        end else if (hst_addr == 14) m_mask = hst_data_i;
      end
      if (|(dev_evt & mask_o)) m_alert_n = 0;
      m_acc = act;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R1", "data_o", {24'b0, hst_data_o}, {24'b0, m_dout});
      check("R1", "data_oe", {31'b0, hst_data_oe}, {31'b0, m_oe});
      check("R9", "req", {31'b0, hst_req}, {31'b0, m_req});
      check("R10", "alert_n", {31'b0, hst_alert_n}, {31'b0, m_alert_n});
      check("R3", "rx_valid", {31'b0, dev_rx_valid}, {31'b0, m_in.size() != 0});
      if (m_in.size() != 0) check("R3", "rx_data", dev_rx_data, m_in[0]);
      check("R2", "tx_ready", {31'b0, dev_tx_ready}, {31'b0, m_out.size() != DEPTH});
      if (dev_rx_valid && dev_rx_ready) n_rx++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(logic [3:0] a, logic [7:0] d);
    tick();
    hst_en_n = 0; hst_ds_n = 0; hst_rw = 0; hst_addr = a; hst_data_i = d;
    tick(3);
    hst_en_n = 1; hst_ds_n = 1; hst_rw = 1;
    tick(2);
  endtask

  task automatic host_read(logic [3:0] a, output logic [7:0] d);
    tick();
    hst_en_n = 0; hst_ds_n = 0; hst_rw = 1; hst_addr = a;
    tick(3);
    d = hst_data_o;
    hst_en_n = 1; hst_ds_n = 1;
    tick(2);
  endtask

  task automatic write_word(logic [3:0] base, logic [31:0] w);
    for (int i = 0; i < 4; i++) host_write(base + 4'(i), w[8*(3-i) +: 8]);
  endtask

  task automatic read_word(logic [3:0] base, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      host_read(base + 4'(i), b);
      w[8*(3-i) +: 8] = b;
    end
  endtask

  task automatic expect_byte(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] b;
    host_read(a, b);
    check(req, $sformatf("read addr %0d", a), {24'b0, b}, {24'b0, exp});
  endtask

  task automatic expect_word(string req, logic [3:0] base, logic [31:0] exp);
    logic [31:0] w;
    read_word(base, w);
    check(req, $sformatf("word at %0d", base), w, exp);
  endtask

  task automatic tx_push(logic [31:0] w);
    tick();
    dev_tx_valid = 1; dev_tx_data = w;
    tick();
    dev_tx_valid = 0;
  endtask

  task automatic evt_pulse(logic [EVT_W-1:0] v);
    tick();
    dev_evt = v;
    tick();
    dev_evt = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    tick(5);
    rst = 0;
    tick();
    // R11 reset state
    check("R11", "req", {31'b0, hst_req}, 32'd1);
    check("R11", "alert_n", {31'b0, hst_alert_n}, 32'd1);
    check("R11", "data_oe", {31'b0, hst_data_oe}, 32'd0);
    check("R11", "data_o", {24'b0, hst_data_o}, 32'd0);
    check("R11", "rx_valid", {31'b0, dev_rx_valid}, 32'd0);
    check("R11", "tx_ready", {31'b0, dev_tx_ready}, 32'd1);

    // R2 address map
    expect_byte("R2", 4'd15, 8'h00);
    expect_byte("R2", 4'd14, 8'h00);
    host_write(4'd14, 8'h05);
    expect_byte("R2", 4'd14, 8'h05);
    host_write(4'd9, 8'hFF);
    expect_byte("R2", 4'd9, 8'h00);
    expect_byte("R2", 4'd15, 8'h00);

    // R3 inbound commit, order and drop on full
    write_word(4'd4, 32'h11223344);
    tick(2);
    check("R3", "rx head", dev_rx_data, 32'h11223344);
    for (int i = 0; i < 4; i++) write_word(4'd4, 32'h55000000 + 32'(i));
    expect_byte("R2", 4'd15, 8'h04);
    n_rx = 0;
    dev_rx_ready = 1;
    tick(10);
    check("R3", "words accepted", 32'(n_rx), 32'd4);

    // R4 outbound pipeline, R9 read-mode request
    tx_push(32'hA1B2C3D4);
    tx_push(32'h01020304);
    tick(3);
    check("R9", "req read mode, data waiting", {31'b0, hst_req}, 32'd0);
    expect_byte("R2", 4'd15, 8'h02);
    expect_word("R4", 4'd4, 32'h00000000);
    expect_word("R4", 4'd4, 32'hA1B2C3D4);
    expect_word("R4", 4'd4, 32'h01020304);
    tick(3);
    check("R9", "req read mode, empty", {31'b0, hst_req}, 32'd1);
    expect_word("R4", 4'd4, 32'h00000000);

    // R6 pipelined status, R7 toggle, R8 mode
    expect_word("R6", 4'd0, 32'h0);
    write_word(4'd0, 32'h11000000);
    expect_word("R6", 4'd0, 32'h0);
    expect_word("R7", 4'd0, 32'h00000003);
    check("R9", "req write mode, space", {31'b0, hst_req}, 32'd1);
    dev_rx_ready = 0;
    for (int i = 0; i < 4; i++) write_word(4'd4, 32'h66000000 + 32'(i));
    tick(3);
    check("R9", "req write mode, full", {31'b0, hst_req}, 32'd0);
    dev_rx_ready = 1;
    tick(10);
    check("R9", "req write mode, drained", {31'b0, hst_req}, 32'd1);

    // R10 alert masking, stickiness, priority
    evt_pulse(8'h02);
    tick(3);
    check("R10", "masked event", {31'b0, hst_alert_n}, 32'd1);
    evt_pulse(8'h04);
    tick(3);
    check("R10", "enabled event", {31'b0, hst_alert_n}, 32'd0);
    write_word(4'd0, 32'h22000000);
    tick(3);
    check("R10", "other message keeps alert", {31'b0, hst_alert_n}, 32'd0);
    expect_byte("R8", 4'd15, 8'h01);
    expect_word("R6", 4'd0, 32'h00000003);
    expect_word("R7", 4'd0, 32'h00000006);
    write_word(4'd0, 32'h10000001);
    expect_byte("R5", 4'd15, 8'h01);
    tick();
    dev_evt = 8'h04;
    write_word(4'd0, 32'h01000000);
    dev_evt = '0;
    tick(3);
    check("R10", "event beats ack", {31'b0, hst_alert_n}, 32'd0);
    write_word(4'd0, 32'h01000000);
    tick(3);
    check("R10", "ack clears", {31'b0, hst_alert_n}, 32'd1);
    expect_word("R6", 4'd0, 32'h00000006);
    expect_word("R7", 4'd0, 32'h00000003);
    write_word(4'd0, 32'h10000000);
    expect_byte("R8", 4'd15, 8'h00);
    tick(3);
    check("R9", "req back in read mode", {31'b0, hst_req}, 32'd1);
    tick(5);
    finish_run();
  end
endmodule